// File: doc/BRIEF.md
# Staged Core Supply Switch Sequencer

This block drives the eight-segment supply switch of one processor core. When it turns the switch on, it closes the segments a few at a time, so the core's supply rises gradually and inrush current stays low. When it turns the switch off, it opens all segments together. Code 0xFF means every segment is open and the core is unpowered. Code 0x00 means every segment is closed and the core is fully powered.

A power controller raises a one-cycle on-request or off-request. It then waits for the one-cycle completion pulse. The switch reports its actual code on a sense input. The sequencer decides from that sense value whether any work is needed at all. It also declares completion only once the sense value equals the target code. Every wait is counted in clock cycles, derived from a parameter that gives the number of cycles per microsecond.

Top module: `pwr_ramp_seq`

## Requirements
- R1: While reset is held and after it is released, `swCtrl` is 0xFF and both `busy` and `done` are 0.
- R2: An accepted on-request drives `swCtrl` through 0xFE, 0xF8, 0xE0, 0xC0, 0x80 and finally 0x00, in that order. The first code appears in the cycle after the request is sampled.
- R3: With C = `CYC_PER_US`, the six on-steps hold their codes for 20·C, 10·C, 10·C, 10·C, 10·C and 20·C cycles respectively.
- R4: An accepted off-request drives 0xFF in the cycle after the request is sampled. The block then stays busy for 30·C cycles before it checks the sense input.
- R5: An on-request made while `swSense` reads 0x00 changes no code and never raises `busy`. `done` is high in the next cycle.
- R6: An off-request made while `swSense` reads 0xFF changes no code and never raises `busy`. `done` is high in the next cycle.
- R7: After the last dwell, the block stays busy until `swSense` equals the target code (0x00 for on, 0xFF for off). Completion follows one cycle after the first cycle in which they match.
- R8: A request of either kind made while `busy` is high has no effect on `swCtrl` or on the timing.
- R9: `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R10: When both requests are high in the same idle cycle, the off-request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enReq | input | 1 | Request to close the switch (power the core) |
| disReq | input | 1 | Request to open the switch (unpower the core) |
| swSense | input | 8 | Code currently reported by the switch |
| swCtrl | output | 8 | Segment control code driven to the switch |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Let E be the clock edge that samples a request, and let T be 80·C cycles for an on-sequence or 30·C cycles for an off-sequence. On-step k takes effect one cycle after E plus the sum of the earlier dwells. The block enters its settle wait at E+T, and `done` rises one edge after the sense input first matches the target. A skipped request pulses `done` right after E.

The bench holds the sense input at its old value for a chosen number of extra cycles. From that delay and T it computes, for every cycle, the expected code, `busy` and `done`. It compares them at the falling edge, half a cycle away from the edge that updates them.

// File: rtl/pwr_ramp_pkg.sv
package pwr_ramp_pkg;

  localparam int          CODE_W     = 8;
  localparam int          NUM_STEPS  = 6;
  localparam logic [7:0]  CODE_OPEN  = 8'hFF;
  localparam logic [7:0]  CODE_SHUT  = 8'h00;
  localparam int          OFF_US     = 30;
  localparam int          MAX_US     = 30;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RAMP,
    ST_SETTLE
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startOn;
    logic startOff;
    logic nextStep;
  } dpCmd_t;

  // segment code for each on-step; ordering matters
  function automatic logic [7:0] rampCode(input int idx);
    case (idx)
      0:       return 8'hFE;
      1:       return 8'hF8;
      2:       return 8'hE0;
      3:       return 8'hC0;
      4:       return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  // dwell in microseconds after each on-step
  function automatic int rampDwellUs(input int idx);
    case (idx)
      0:       return 20;
      5:       return 20;
      default: return 10;
    endcase
  endfunction

endpackage

// File: rtl/pwr_ramp_dp.sv
module pwr_ramp_dp
  import pwr_ramp_pkg::*;
#(
  parameter int CYC_PER_US = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [CODE_W-1:0] swSense,
  output logic [CODE_W-1:0] swCtrl,
  output logic              dwellDone,
  output logic              lastStep,
  output logic              senseAtTarget,
  output logic              senseIsOn,
  output logic              senseIsOff
);

  localparam int CNT_W  = $clog2(MAX_US * CYC_PER_US + 1);
  localparam int STEP_W = $clog2(NUM_STEPS);

  logic [CODE_W-1:0] codeReg;
  logic [CODE_W-1:0] targetReg;
  logic [STEP_W-1:0] stepIdx;
  logic [CNT_W-1:0]  dwellCnt;
  logic              modeOn;

  function automatic logic [CNT_W-1:0] dwellLoad(input int us);
    return CNT_W'(us * CYC_PER_US - 1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeReg   <= CODE_OPEN;
      targetReg <= CODE_OPEN;
      stepIdx   <= '0;
      dwellCnt  <= '0;
      modeOn    <= 1'b0;
    end else if (cmd.startOff) begin
      codeReg   <= CODE_OPEN;
      targetReg <= CODE_OPEN;
      stepIdx   <= '0;
      dwellCnt  <= dwellLoad(OFF_US);
      modeOn    <= 1'b0;
    end else if (cmd.startOn) begin
      codeReg   <= rampCode(0);
      targetReg <= CODE_SHUT;
      stepIdx   <= '0;
      dwellCnt  <= dwellLoad(rampDwellUs(0));
      modeOn    <= 1'b1;
    end else if (cmd.nextStep) begin
      codeReg   <= rampCode(int'(stepIdx) + 1);
      stepIdx   <= stepIdx + 1'b1;
      dwellCnt  <= dwellLoad(rampDwellUs(int'(stepIdx) + 1));
    end else if (dwellCnt != '0) begin
      dwellCnt  <= dwellCnt - 1'b1;
    end
  end

  assign swCtrl        = codeReg;
  assign dwellDone     = (dwellCnt == '0);
  assign lastStep      = !modeOn || (int'(stepIdx) == NUM_STEPS - 1);
  assign senseAtTarget = (swSense == targetReg);
  assign senseIsOn     = (swSense == CODE_SHUT);
  assign senseIsOff    = (swSense == CODE_OPEN);

  // R2
  ramp_monotone_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.startOff |=> ((codeReg & ~$past(codeReg)) == '0));

  // R3
  dwell_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dwellCnt != '0 && !cmd.startOn && !cmd.startOff && !cmd.nextStep)
      |=> (dwellCnt == CNT_W'($past(dwellCnt) - 1'b1)));

endmodule

// File: rtl/pwr_ramp_ctrl.sv
module pwr_ramp_ctrl
  import pwr_ramp_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   enReq,
  input  logic   disReq,
  input  logic   dwellDone,
  input  logic   lastStep,
  input  logic   senseAtTarget,
  input  logic   senseIsOn,
  input  logic   senseIsOff,
  output dpCmd_t cmd,
  output logic   busy,
  output logic   done
);

  seqState_t state, stateNxt;
  logic      doneNxt;

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    doneNxt  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (disReq) begin
          if (senseIsOff) doneNxt = 1'b1;
          else begin
            cmd.startOff = 1'b1;
            stateNxt     = ST_RAMP;
          end
        end else if (enReq) begin
          if (senseIsOn) doneNxt = 1'b1;
          else begin
            cmd.startOn = 1'b1;
            stateNxt    = ST_RAMP;
          end
        end
      end
      ST_RAMP: begin
        if (dwellDone) begin
          if (lastStep) stateNxt = ST_SETTLE;
          else          cmd.nextStep = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (senseAtTarget) begin
          stateNxt = ST_IDLE;
          doneNxt  = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      done  <= doneNxt;
    end
  end

  assign busy = (state != ST_IDLE);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SETTLE && !senseAtTarget) |=> (state == ST_SETTLE && !done));

  // R8
  ramp_stay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RAMP) |=> (state != ST_IDLE));

endmodule

// File: rtl/pwr_ramp_seq.sv
module pwr_ramp_seq
  import pwr_ramp_pkg::*;
#(
  parameter int CYC_PER_US = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enReq,
  input  logic       disReq,
  input  logic [7:0] swSense,
  output logic [7:0] swCtrl,
  output logic       busy,
  output logic       done
);

  dpCmd_t cmd;
  logic   dwellDone, lastStep, senseAtTarget, senseIsOn, senseIsOff;

  pwr_ramp_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .enReq         (enReq),
    .disReq        (disReq),
    .dwellDone     (dwellDone),
    .lastStep      (lastStep),
    .senseAtTarget (senseAtTarget),
    .senseIsOn     (senseIsOn),
    .senseIsOff    (senseIsOff),
    .cmd           (cmd),
    .busy          (busy),
    .done          (done)
  );

  pwr_ramp_dp #(.CYC_PER_US(CYC_PER_US)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .cmd           (cmd),
    .swSense       (swSense),
    .swCtrl        (swCtrl),
    .dwellDone     (dwellDone),
    .lastStep      (lastStep),
    .senseAtTarget (senseAtTarget),
    .senseIsOn     (senseIsOn),
    .senseIsOff    (senseIsOff)
  );

  // R4
  off_snap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && disReq && swSense != 8'hFF) |=> (swCtrl == 8'hFF && busy));

  // R10
  off_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && disReq && enReq && swSense != 8'hFF) |=> (swCtrl == 8'hFF));

endmodule

// File: tb/pwr_ramp_seq_bench.sv
`timescale 1ns/1ps
module pwr_ramp_seq_bench;

  localparam int C = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enReq = 1'b0;
  logic       disReq = 1'b0;
  logic       forceSense = 1'b0;
  logic [7:0] staleVal = 8'hFF;
  logic [7:0] swSense, swCtrl;
  logic       busy, done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [7:0] curCode = 8'hFF;

  assign swSense = forceSense ? staleVal : swCtrl;

  always #10 clk = ~clk;

  pwr_ramp_seq #(.CYC_PER_US(C)) u_pwr_ramp_seq (
    .clk(clk), .rstN(rstN), .enReq(enReq), .disReq(disReq),
    .swSense(swSense), .swCtrl(swCtrl), .busy(busy), .done(done)
  );

  function automatic logic [7:0] stepCodeB(input int i);
    logic [7:0] t [6] = '{8'hFE, 8'hF8, 8'hE0, 8'hC0, 8'h80, 8'h00};
    return t[i];
  endfunction

  function automatic int stepCycB(input int i);
    return ((i == 0 || i == 5) ? 20 : 10) * C;
  endfunction

  // code expected at the j-th falling edge after the request edge (j >= 1)
  function automatic logic [7:0] onCodeAt(input int j);
    int acc = 0;
    for (int i = 0; i < 6; i++) begin
      acc += stepCycB(i);
      if (j <= acc) return stepCodeB(i);
    end
    return 8'h00;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [7:0] aCode, input logic aBusy, input logic aDone,
                       input logic [7:0] eCode, input logic eBusy, input logic eDone);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got code=%h busy=%b done=%b, want code=%h busy=%b done=%b",
               req, aCode, aBusy, aDone, eCode, eBusy, eDone);
    end
  endtask

  task automatic expectNow(input string req, input logic [7:0] eCode,
                           input logic eBusy, input logic eDone);
    check(swCtrl === eCode && busy === eBusy && done === eDone, req,
          swCtrl, busy, done, eCode, eBusy, eDone);
  endtask

  // en: on-request; both: raise both requests; stall: extra stale-sense cycles;
  // injAt: falling edge index for a request while busy (0 = none)
  task automatic runOp(input bit en, input bit both, input int stall, input int injAt);
    logic [7:0] tgt;
    bit   isOn;
    int   t;
    tgt  = (en && !both) ? 8'h00 : 8'hFF;
    isOn = (tgt == 8'h00);
    @(negedge clk);
    enReq  = en | both;
    disReq = !en | both;
    if (curCode != tgt) begin
      staleVal   = curCode;
      forceSense = 1'b1;
    end
    @(negedge clk);
    enReq  = 1'b0;
    disReq = 1'b0;
    if (curCode == tgt) begin
      expectNow(isOn ? "R5 skip on" : "R6 skip off", curCode, 1'b0, 1'b1);
      @(negedge clk);
      expectNow("R9 skip pulse end", curCode, 1'b0, 1'b0);
      return;
    end
    t = isOn ? 80 * C : 30 * C;
    for (int j = 1; j <= t + 2 + stall; j++) begin
      if (j <= t)
        expectNow(both ? "R10 off wins" : (isOn ? "R2 R3 ramp" : "R4 off hold"),
                  isOn ? onCodeAt(j) : 8'hFF, 1'b1, 1'b0);
      else if (j <= t + 1 + stall)
        expectNow("R7 settle wait", tgt, 1'b1, 1'b0);
      else
        expectNow("R7 R9 completion", tgt, 1'b0, 1'b1);
      if (j == t + 1 + stall) forceSense = 1'b0;
      if (j == injAt) begin
        enReq  = 1'b1;
        disReq = 1'b1;
      end else begin
        enReq  = 1'b0;
        disReq = 1'b0;
      end
      @(negedge clk);
    end
    enReq  = 1'b0;
    disReq = 1'b0;
    expectNow("R9 single pulse", tgt, 1'b0, 1'b0);
    curCode = tgt;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    expectNow("R1 in reset", 8'hFF, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    expectNow("R1 after reset", 8'hFF, 1'b0, 1'b0);

    runOp(1'b0, 1'b0, 0, 0);            // R6 off while already off
    runOp(1'b1, 1'b0, 0, 0);            // R2 R3 plain ramp
    runOp(1'b1, 1'b0, 0, 0);            // R5 on while already on
    runOp(1'b0, 1'b0, 3, 0);            // R4 R7 off with late sense
    runOp(1'b1, 1'b0, 7, 25 * C);       // R8 request mid-ramp, R7 stall
    runOp(1'b1, 1'b1, 0, 5);            // R10 both at once from on
    runOp(1'b1, 1'b0, 0, 80 * C);       // R8 request on the last dwell cycle
    runOp(1'b0, 1'b0, 0, 1);            // R8 request right after off start

    for (int k = 0; k < 14; k++) begin
      bit en, both;
      int st, inj;
      en   = 1'($urandom_range(0, 1));
      both = ($urandom_range(0, 5) == 0);
      st   = $urandom_range(0, 9);
      inj  = ($urandom_range(0, 1) == 1) ? $urandom_range(1, 30 * C) : 0;
      runOp(en, both, st, inj);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got no end, want end before 200000 cycles");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule